// File: doc/BRIEF.md
# I2C Target Receive Byte Path

This block is the receive side of an I2C target once the bus front end has recognised the target's address. The front end hands over one strobe per address hit and one strobe per data bit with the bit's value. The block assembles each byte in an 8-bit shift register and moves it into a receive FIFO. Firmware drains the FIFO through a read port.

The block works out the acknowledge value the front end drives in each ACK slot. When the FIFO still holds unread bytes, it can decline a new address match. It also raises overflow, threshold, interactive-receive and refusal flags, and offers a flush control that clears itself.

In interactive mode, firmware chooses the returned ACK bit for every byte. The interactive flag doubles as the request to stretch SCL until firmware has made that choice.

Top module: `i2ct_rx_path`

## Requirements
- R1: Data bits arrive MSB first. On the clock edge that samples the eighth `bit_stb` of a byte, the assembled byte enters the FIFO and `level` increments, provided the FIFO is not full. A read with `rd_en` presents the oldest byte on `rd_data` after the same edge, and `level` decrements.
- R2: A read while the FIFO is empty leaves `rd_data` at its previous value and leaves `level` at 0.
- R3: One edge after each cycle, `data_ack_bit` equals `irx_ack_bit` when `irx_mode` was 1, where 0 means ACK (SDA pulled low) and 1 means NACK (SDA released). It is 0 (ACK) whenever `irx_mode` was 0, whatever `irx_ack_bit` holds.
- R4: With `irx_mode` at 1, `irx_flag` rises on the edge of the eighth bit of every byte. It stays high, telling the front end to stretch SCL, until `irx_clr` is pulsed.
- R5: On `addr_hit` with `dnr_mode` at 1 and `level` not 0, `addr_ack_bit` becomes 1 (NACK) and `dnr_err` is set until `dnr_clr`. Data bits of that refused transfer are not stored. On any other `addr_hit`, `addr_ack_bit` becomes 0 (ACK).
- R6: A byte that completes while the FIFO is full stays in the shift register and `level` does not change. One edge after a read frees a slot, the held byte enters the FIFO behind the older bytes.
- R7: The first data bit of a new byte that arrives while a byte is held and the FIFO is full sets `ovf_flag` until `ovf_clr`. That new byte is discarded.
- R8: `thr_flag` is high exactly while `level` is greater than or equal to `thresh`. It drops by itself once the level falls below it.
- R9: A `flush_set` pulse makes `flush_bit` read 1 for one cycle. On the following edge the FIFO and any held byte are cleared, `level` becomes 0 and `flush_bit` returns to 0.
- R10: One edge after `enable` is low, `level` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable; low clears FIFO, byte state and flags |
| irx_mode | input | 1 | Interactive receive mode select |
| irx_ack_bit | input | 1 | Firmware ACK choice, 0 ACK, 1 NACK |
| dnr_mode | input | 1 | Refuse address match while FIFO holds data |
| thresh | input | LW | Receive threshold level |
| flush_set | input | 1 | Write-one pulse requesting a flush |
| ovf_clr | input | 1 | Clear overflow flag |
| dnr_clr | input | 1 | Clear refusal error flag |
| irx_clr | input | 1 | Clear interactive flag, releasing the stretch |
| addr_hit | input | 1 | Front end strobe: own address recognised |
| bit_stb | input | 1 | Front end strobe: one data bit sampled |
| bit_val | input | 1 | Value of the sampled data bit |
| rd_en | input | 1 | FIFO read request |
| flush_bit | output | 1 | Flush control readback, self-clearing |
| addr_ack_bit | output | 1 | Bit to drive in the address ACK slot |
| data_ack_bit | output | 1 | Bit to drive in data ACK slots |
| irx_flag | output | 1 | Interactive flag and SCL stretch request |
| rd_data | output | 8 | FIFO read data |
| level | output | LW | Bytes held in the FIFO |
| thr_flag | output | 1 | Level at or above threshold |
| ovf_flag | output | 1 | Receive overflow flag |
| dnr_err | output | 1 | Address match refused flag |

## Verification
Byte storage, `rd_data`, `addr_ack_bit`, `dnr_err`, `ovf_flag`, `irx_flag`, `flush_bit` and `data_ack_bit` are all due one edge after the strobe or input that causes them. `thr_flag` follows `level` in the same cycle. Two results take more than one edge: a held byte enters the FIFO one edge after the read that frees a slot, and a flush clears the FIFO one edge after `flush_bit` goes high. The bench drives inputs and samples outputs 1 ns after a rising edge. It compares each result only after counting the edges that lead to it, which is why the overflow and flush checks insert an extra cycle before comparing.

// File: rtl/i2ct_rx_pkg.sv
package i2ct_rx_pkg;
   localparam int unsigned BYTE_W = 8;

   typedef enum logic {
      ACK_DRIVE   = 1'b0,
      ACK_RELEASE = 1'b1
   } ackbit_e;

   function automatic int unsigned cnt_bits(input int unsigned n);
      return $clog2(n + 1);
   endfunction
endpackage

// File: rtl/i2ct_rx_fifo.sv
module i2ct_rx_fifo
   import i2ct_rx_pkg::*;
#(
   parameter int unsigned DEPTH = 8,
   parameter int unsigned W     = BYTE_W,
   localparam int unsigned AW   = $clog2(DEPTH),
   localparam int unsigned LW   = cnt_bits(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          push,
   input  logic [W-1:0]  push_data,
   input  logic          pop,
   output logic [W-1:0]  rd_data,
   output logic [LW-1:0] level,
   output logic          full,
   output logic          empty
);
   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wptr, rptr, wr_nxt, rd_nxt;
   logic          push_ok, pop_ok;

   assign full    = (level == LW'(DEPTH));
   assign empty   = (level == '0);
   assign push_ok = push && !full;
   assign pop_ok  = pop && !empty;

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_wrap_pow2
         assign wr_nxt = wptr + 1'b1;
         assign rd_nxt = rptr + 1'b1;
      end else begin : g_wrap_mod
         assign wr_nxt = (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
         assign rd_nxt = (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push_ok && !clr) mem[wptr] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr    <= '0;
         rptr    <= '0;
         level   <= '0;
         rd_data <= '0;
      end else begin
         if (pop_ok) rd_data <= mem[rptr];
         if (clr) begin
            wptr  <= '0;
            rptr  <= '0;
            level <= '0;
         end else begin
            if (push_ok) wptr <= wr_nxt;
            if (pop_ok)  rptr <= rd_nxt;
            unique case ({push_ok, pop_ok})
               2'b10:   level <= level + 1'b1;
               2'b01:   level <= level - 1'b1;
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/i2ct_rx_shift.sv
module i2ct_rx_shift
   import i2ct_rx_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              txn_start,
   input  logic              txn_refuse,
   input  logic              bit_stb,
   input  logic              bit_val,
   input  logic              fifo_full,
   output logic              push,
   output logic [BYTE_W-1:0] push_data,
   output logic              byte_end,
   output logic              ovf_evt
);
   localparam int unsigned CW = $clog2(BYTE_W);

   logic [CW-1:0]     cnt;
   logic [BYTE_W-1:0] shreg;
   logic              hold_v, ovf_drop, refused;
   logic              first, take, done_push, done_hold, hold_push;

   assign first     = (cnt == '0);
   assign byte_end  = bit_stb && (cnt == CW'(BYTE_W - 1));
   assign ovf_evt   = bit_stb && first && hold_v && fifo_full && !refused;
   assign take      = bit_stb && !refused && !ovf_drop && !ovf_evt;
   assign hold_push = hold_v && !fifo_full;
   assign done_push = byte_end && take && !hold_v && !fifo_full;
   assign done_hold = byte_end && take && fifo_full;
   assign push      = hold_push || done_push;
   assign push_data = hold_v ? shreg : {shreg[BYTE_W-2:0], bit_val};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt      <= '0;
         shreg    <= '0;
         hold_v   <= 1'b0;
         ovf_drop <= 1'b0;
         refused  <= 1'b0;
      end else if (clr) begin
         cnt      <= '0;
         hold_v   <= 1'b0;
         ovf_drop <= 1'b0;
         refused  <= 1'b0;
      end else begin
         if (txn_start) begin
            cnt      <= '0;
            refused  <= txn_refuse;
            ovf_drop <= 1'b0;
         end else if (bit_stb) begin
            cnt <= cnt + 1'b1;
            if (ovf_evt)       ovf_drop <= 1'b1;
            else if (byte_end) ovf_drop <= 1'b0;
            if (take) shreg <= {shreg[BYTE_W-2:0], bit_val};
         end
         if (hold_push)      hold_v <= 1'b0;
         else if (done_hold) hold_v <= 1'b1;
      end
   end
endmodule

// File: rtl/i2ct_rx_path.sv
module i2ct_rx_path
   import i2ct_rx_pkg::*;
#(
   parameter int unsigned DEPTH = 8,
   localparam int unsigned LW   = cnt_bits(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              irx_mode,
   input  logic              irx_ack_bit,
   input  logic              dnr_mode,
   input  logic [LW-1:0]     thresh,
   input  logic              flush_set,
   input  logic              ovf_clr,
   input  logic              dnr_clr,
   input  logic              irx_clr,
   input  logic              addr_hit,
   input  logic              bit_stb,
   input  logic              bit_val,
   input  logic              rd_en,
   output logic              flush_bit,
   output logic              addr_ack_bit,
   output logic              data_ack_bit,
   output logic              irx_flag,
   output logic [BYTE_W-1:0] rd_data,
   output logic [LW-1:0]     level,
   output logic              thr_flag,
   output logic              ovf_flag,
   output logic              dnr_err
);
   generate
      if (DEPTH < 2 || DEPTH > 256) begin : g_bad_depth
         $error("i2ct_rx_path: DEPTH must lie in 2..256");
      end
   endgenerate

   logic              fifo_clr, fifo_full, fifo_empty, refuse;
   logic              push, byte_end, ovf_evt;
   logic [BYTE_W-1:0] push_data;

   assign fifo_clr = flush_bit || !enable;
   assign refuse   = addr_hit && dnr_mode && !fifo_empty;
   assign thr_flag = (level >= thresh);

   i2ct_rx_shift u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (fifo_clr),
      .txn_start  (addr_hit),
      .txn_refuse (refuse),
      .bit_stb    (bit_stb),
      .bit_val    (bit_val),
      .fifo_full  (fifo_full),
      .push       (push),
      .push_data  (push_data),
      .byte_end   (byte_end),
      .ovf_evt    (ovf_evt)
   );

   i2ct_rx_fifo #(.DEPTH(DEPTH), .W(BYTE_W)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (fifo_clr),
      .push      (push),
      .push_data (push_data),
      .pop       (rd_en),
      .rd_data   (rd_data),
      .level     (level),
      .full      (fifo_full),
      .empty     (fifo_empty)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flush_bit    <= 1'b0;
         addr_ack_bit <= ACK_DRIVE;
         data_ack_bit <= ACK_DRIVE;
         irx_flag     <= 1'b0;
         ovf_flag     <= 1'b0;
         dnr_err      <= 1'b0;
      end else if (!enable) begin
         flush_bit    <= 1'b0;
         addr_ack_bit <= ACK_DRIVE;
         data_ack_bit <= ACK_DRIVE;
         irx_flag     <= 1'b0;
         ovf_flag     <= 1'b0;
         dnr_err      <= 1'b0;
      end else begin
         flush_bit    <= flush_set;
         data_ack_bit <= irx_mode ? irx_ack_bit : ACK_DRIVE;
         if (addr_hit) addr_ack_bit <= refuse ? ACK_RELEASE : ACK_DRIVE;
         if (byte_end && irx_mode) irx_flag <= 1'b1;
         else if (irx_clr)         irx_flag <= 1'b0;
         if (ovf_evt)      ovf_flag <= 1'b1;
         else if (ovf_clr) ovf_flag <= 1'b0;
         if (refuse)       dnr_err <= 1'b1;
         else if (dnr_clr) dnr_err <= 1'b0;
      end
   end
endmodule

// File: rtl/i2ct_rx_chk.sv
module i2ct_rx_chk #(
   parameter int unsigned LW = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          enable,
   input logic          irx_mode,
   input logic          irx_clr,
   input logic          addr_hit,
   input logic          bit_stb,
   input logic          rd_en,
   input logic          flush_bit,
   input logic          data_ack_bit,
   input logic          irx_flag,
   input logic [7:0]    rd_data,
   input logic [LW-1:0] level,
   input logic          ovf_flag,
   input logic          dnr_err
);
   // R3
   ack_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(irx_mode) |-> (data_ack_bit == 1'b0));

   // R2
   empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && level == '0) |=> $stable(rd_data));

   // R4
   irx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irx_flag && !irx_clr && enable) |=> irx_flag);

   // R5
   dnr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dnr_err) |-> $past(addr_hit));

   // R7
   ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_flag) |-> $past(bit_stb));

   // R9
   flush_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush_bit |=> (!flush_bit && level == '0));

   // R10
   disable_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (level == '0));
endmodule

bind i2ct_rx_path i2ct_rx_chk #(.LW(LW)) u_chk (.*);

// File: tb/i2ct_rx_path_tb.sv
`timescale 1ns/1ps
module i2ct_rx_path_tb;
   localparam int DEPTH = 8;
   localparam int LW    = $clog2(DEPTH + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic enable = 1'b0, irx_mode = 1'b0, irx_ack_bit = 1'b0, dnr_mode = 1'b0;
   logic [LW-1:0] thresh = LW'(3);
   logic flush_set = 1'b0, ovf_clr = 1'b0, dnr_clr = 1'b0, irx_clr = 1'b0;
   logic addr_hit = 1'b0, bit_stb = 1'b0, bit_val = 1'b0, rd_en = 1'b0;
   logic flush_bit, addr_ack_bit, data_ack_bit, irx_flag, thr_flag, ovf_flag, dnr_err;
   logic [7:0] rd_data;
   logic [LW-1:0] level;

   int vecs = 0;
   int fails = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   i2ct_rx_path #(.DEPTH(DEPTH)) u_dut (.*);

   task automatic cyc();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      vecs++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s got=%0h exp=%0h", req, got, exp);
      end
   endtask

   task automatic send_bit(input logic b);
      bit_stb = 1'b1; bit_val = b; cyc();
      bit_stb = 1'b0; cyc();
   endtask

   task automatic send_byte(input logic [7:0] v);
      for (int i = 7; i >= 0; i--) send_bit(v[i]);
   endtask

   task automatic addr();
      addr_hit = 1'b1; cyc(); addr_hit = 1'b0;
   endtask

   task automatic rd();
      rd_en = 1'b1; cyc(); rd_en = 1'b0;
   endtask

   function automatic logic exp_thr(input int lvl, input int th);
      return lvl >= th;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
         $finish;
      end
   end

   initial begin
      logic [7:0] q [$];
      logic [7:0] last;
      void'($urandom(32'd1234));
      repeat (3) cyc();
      rst_n = 1'b1; cyc();
      enable = 1'b1; cyc();

      // reset state
      chk("R1 reset level", level, 0);
      chk("R7 reset ovf", ovf_flag, 0);
      chk("R4 reset irx", irx_flag, 0);
      chk("R5 reset addr ack", addr_ack_bit, 0);

      // R1 / R8 directed
      addr();
      chk("R5 plain ack", addr_ack_bit, 0);
      send_byte(8'hA5); send_byte(8'h3C);
      chk("R1 level 2", level, 2);
      chk("R8 below thr", thr_flag, 0);
      send_byte(8'h81);
      chk("R8 at thr", thr_flag, 1);
      rd();
      chk("R1 first byte", rd_data, 8'hA5);
      chk("R8 drops", thr_flag, 0);
      rd(); chk("R1 second byte", rd_data, 8'h3C);
      rd(); chk("R1 third byte", rd_data, 8'h81);
      chk("R1 level 0", level, 0);

      // R2 empty read
      rd();
      chk("R2 rd_data kept", rd_data, 8'h81);
      chk("R2 level kept", level, 0);

      // R3 ack choice
      irx_mode = 1'b1; irx_ack_bit = 1'b1; cyc();
      chk("R3 irx nack", data_ack_bit, 1);
      irx_ack_bit = 1'b0; cyc();
      chk("R3 irx ack", data_ack_bit, 0);
      irx_ack_bit = 1'b1; irx_mode = 1'b0; cyc();
      chk("R3 forced ack", data_ack_bit, 0);

      // R4 interactive flag
      irx_mode = 1'b1; irx_ack_bit = 1'b0;
      send_byte(8'h5A);
      chk("R4 irx set", irx_flag, 1);
      cyc();
      chk("R4 irx held", irx_flag, 1);
      irx_clr = 1'b1; cyc(); irx_clr = 1'b0;
      chk("R4 irx cleared", irx_flag, 0);
      irx_mode = 1'b0;

      // R5 refusal
      dnr_mode = 1'b1;
      addr();
      chk("R5 refuse nack", addr_ack_bit, 1);
      chk("R5 dnr err", dnr_err, 1);
      send_byte(8'hFF);
      chk("R5 refused data dropped", level, 1);
      dnr_clr = 1'b1; cyc(); dnr_clr = 1'b0;
      chk("R5 dnr clear", dnr_err, 0);
      rd(); chk("R5 stored byte", rd_data, 8'h5A);
      addr();
      chk("R5 empty accepts", addr_ack_bit, 0);
      dnr_mode = 1'b0;

      // R6 / R7 overflow
      for (int i = 0; i < DEPTH + 1; i++) send_byte(8'h10 + 8'(i));
      chk("R6 level stays full", level, DEPTH);
      chk("R7 no ovf yet", ovf_flag, 0);
      send_bit(1'b1);
      chk("R7 ovf set", ovf_flag, 1);
      for (int i = 0; i < 7; i++) send_bit(1'b0);
      chk("R7 dropped byte", level, DEPTH);
      rd();
      chk("R6 oldest out", rd_data, 8'h10);
      chk("R6 slot free", level, DEPTH - 1);
      cyc();
      chk("R6 held byte in", level, DEPTH);
      for (int i = 1; i < DEPTH + 1; i++) begin
         rd(); chk("R6 order", rd_data, 8'h10 + 8'(i));
      end
      chk("R7 level empty", level, 0);
      ovf_clr = 1'b1; cyc(); ovf_clr = 1'b0;
      chk("R7 ovf clear", ovf_flag, 0);

      // R9 flush
      send_byte(8'h01); send_byte(8'h02);
      flush_set = 1'b1; cyc(); flush_set = 1'b0;
      chk("R9 flush bit", flush_bit, 1);
      chk("R9 level before", level, 2);
      cyc();
      chk("R9 flush self-clear", flush_bit, 0);
      chk("R9 level flushed", level, 0);

      // R10 enable
      send_byte(8'h77);
      chk("R10 level 1", level, 1);
      enable = 1'b0; cyc();
      chk("R10 cleared", level, 0);
      enable = 1'b1; cyc();
      addr();

      // random rounds
      last = rd_data;
      for (int r = 0; r < 24; r++) begin
         int n;
         n = 1 + int'($urandom % DEPTH);
         thresh = LW'($urandom % (DEPTH + 1));
         q.delete();
         for (int k = 0; k < n; k++) begin
            logic [7:0] v;
            v = 8'($urandom);
            q.push_back(v);
            send_byte(v);
         end
         chk("R1 random level", level, n);
         chk("R8 random thr", thr_flag, exp_thr(n, int'(thresh)));
         for (int k = 0; k < n; k++) begin
            rd();
            last = q.pop_front();
            chk("R1 random data", rd_data, last);
         end
         if ($urandom % 2 == 0) begin
            rd();
            chk("R2 random empty read", rd_data, last);
         end
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
   end
endmodule